// File: doc/BRIEF.md
# Set/Clear Control Register Bank

This block holds two 64-bit control vectors for the rest of the chip: one line per peripheral reset and one bit per peripheral clock stop. Each 64-bit group is held as two 32-bit words. Each word is reached at two offsets on a simple register bus. A write to the first offset turns on the bits written as one. A write to the second offset, four bytes higher, turns those bits off. Bits written as zero are never disturbed, so software can drive single lines without a read-modify-write.

Line k of either group sits at bit k modulo 32 of the lower word when k is below 32, and of the upper word otherwise. Reads return the word through either of its two offsets, one cycle after the read strobe. Offsets that do not belong to a word read as zero and swallow writes. Out of reset every peripheral is held in reset and every clock is stopped, except the bits named in two parameter masks. Those come up released or running.

Top module: `scr_bank`

## Requirements
- R1: Reset line k (0..63) is driven on `rst_lines[k]` and lives in bit k mod 32 of the word at offset 0x040 (k < 32) or 0x050 (k >= 32). Clock-stop bit k is driven on `clk_stop[k]` and lives in the same bit of the word at 0x080 (k < 32) or 0x090 (k >= 32).
- R2: A write to a word's base offset sets exactly the bits written as one. The outputs show the new value in the cycle after the write edge.
- R3: A write to base + 0x4 clears exactly the bits written as one. The outputs show the new value in the cycle after the write edge.
- R4: Bits written as zero, through either offset, keep their value.
- R5: A read strobe at a word's base or base + 0x4 offset loads that word's value into `bus_rdata` at the next clock edge. `bus_rdata` holds its value in any cycle without a read strobe.
- R6: Under reset, `rst_lines` becomes the inverse of `RST_KEEP_MASK` and `clk_stop` becomes the inverse of `CLK_RUN_MASK`, so a one means held in reset or stopped. `bus_rdata` becomes zero.
- R7: A read of any other offset returns zero. A write to any other offset changes no bit.
- R8: When a read and a write hit the same word in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| rst_lines | output | 64 | Peripheral reset lines, one = held in reset |
| clk_stop | output | 64 | Peripheral clock stops, one = stopped |

## Verification
A read and a write can land in the same cycle, on the same word or on different ones. This matters most when the write goes to the clear offset and the read goes to the base offset of the same word. The bench forces this case with a directed step. The check is that `bus_rdata` carries the value from before the write, while `rst_lines` already shows the cleared bits one cycle later. A long stretch of pseudo-random traffic then mixes both strobes across mapped and unmapped offsets. A behavioural model compares both output vectors and the read data on every clock.

// File: rtl/scr_pkg.sv
// Package: shared constants and types for the set/clear register bank.
// Assumes a fixed bank of four words: reset low, reset high, clock low, clock high.
package scr_pkg;
    localparam int NUM_WORDS = 4;

    // Word slots in the bank; the order fixes where each word sits in packed vectors.
    typedef enum logic [1:0] {
        W_RST_LO = 2'd0,
        W_RST_HI = 2'd1,
        W_CLK_LO = 2'd2,
        W_CLK_HI = 2'd3
    } scr_word_e;
endpackage

// File: rtl/scr_decode.sv
// Module: scr_decode
// Turns the bus offset into per-word select lines. Each word has a set offset
// (its base) and a clear offset (base plus CLR_DELTA). Assumes all offsets are distinct.
module scr_decode #(
    parameter int ADDR_W    = 12,
    parameter int NWORDS    = 4,
    parameter int CLR_DELTA = 4,
    parameter logic [NWORDS*ADDR_W-1:0] BASES = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [NWORDS-1:0] set_sel,
    output logic [NWORDS-1:0] clr_sel,
    output logic [NWORDS-1:0] rd_sel,
    output logic              mapped
);
    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        localparam logic [ADDR_W-1:0] SET_OFS = BASES[i*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] CLR_OFS = SET_OFS + ADDR_W'(CLR_DELTA);

        // Compare the offset against this word's two aliases.
        always_comb begin
            set_sel[i] = wr && (addr == SET_OFS);
            clr_sel[i] = wr && (addr == CLR_OFS);
            rd_sel[i]  = (addr == SET_OFS) || (addr == CLR_OFS);
        end
    end

    // Any alias of any word counts as a mapped offset.
    assign mapped = |rd_sel;

    // R1: at most one word and one alias is touched by any write.
    assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_sel, clr_sel}));
endmodule

// File: rtl/scr_word.sv
// Module: scr_word
// One 32-bit control word. A set strobe ORs the data in, a clear strobe masks
// it out. Assumes set and clear never arrive together (decode guarantees it).
module scr_word #(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] RESET_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Hold the word; apply set or clear with the written ones as mask.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= RESET_VAL;
        else if (set_en) q <= q | wdata;
        else if (clr_en) q <= q & ~wdata;
    end

    assert_reset_R6: assert property (@(posedge clk)
        !rst_n |=> (q == RESET_VAL));

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(wdata)) == $past(wdata)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((q & $past(wdata)) == '0));

    assert_keep_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en || clr_en) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(q));
endmodule

// File: rtl/scr_rdmux.sv
// Module: scr_rdmux
// Registers read data from the selected word on a read strobe, and holds it
// otherwise. Assumes rd_sel is one-hot or zero; zero yields a zero result.
module scr_rdmux #(
    parameter int DATA_W = 32,
    parameter int NWORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd,
    input  logic [NWORDS-1:0]        rd_sel,
    input  logic                     mapped,
    input  logic [NWORDS*DATA_W-1:0] words,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] pick;

    // AND-OR select of the addressed word.
    always_comb begin
        pick = '0;
        for (int i = 0; i < NWORDS; i++) begin
            pick = pick | (words[i*DATA_W +: DATA_W] & {DATA_W{rd_sel[i]}});
        end
    end

    // Capture on a read strobe, otherwise keep the last result.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= pick;
    end

    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !mapped) |=> (rdata == '0));

    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/scr_bank.sv
// Module: scr_bank (top)
// Set/clear control register bank. It drives 64 reset lines and 64 clock-stop
// bits, each group split over two 32-bit words. Each word has a set offset and a
// clear offset four bytes higher. Assumes a single-cycle register bus with no wait states.
module scr_bank #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int CLR_DELTA = 4,
    parameter logic [ADDR_W-1:0] RST_LO_OFS = 12'h040,
    parameter logic [ADDR_W-1:0] RST_HI_OFS = 12'h050,
    parameter logic [ADDR_W-1:0] CLK_LO_OFS = 12'h080,
    parameter logic [ADDR_W-1:0] CLK_HI_OFS = 12'h090,
    parameter logic [2*DATA_W-1:0] RST_KEEP_MASK = '0,
    parameter logic [2*DATA_W-1:0] CLK_RUN_MASK  = 64'h0000_0004_0000_0071
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [2*DATA_W-1:0] rst_lines,
    output logic [2*DATA_W-1:0] clk_stop
);
    import scr_pkg::*;

    localparam int NW = NUM_WORDS;
    localparam logic [NW*ADDR_W-1:0] BASES =
        {CLK_HI_OFS, CLK_LO_OFS, RST_HI_OFS, RST_LO_OFS};
    localparam logic [NW*DATA_W-1:0] RESET_ALL = {~CLK_RUN_MASK, ~RST_KEEP_MASK};

    logic [NW-1:0]        set_sel;
    logic [NW-1:0]        clr_sel;
    logic [NW-1:0]        rd_sel;
    logic                 mapped;
    logic [NW*DATA_W-1:0] word_q;

    scr_decode #(
        .ADDR_W(ADDR_W), .NWORDS(NW), .CLR_DELTA(CLR_DELTA), .BASES(BASES)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
        .set_sel(set_sel), .clr_sel(clr_sel), .rd_sel(rd_sel), .mapped(mapped)
    );

    for (genvar i = 0; i < NW; i++) begin : g_reg
        scr_word #(
            .DATA_W(DATA_W), .RESET_VAL(RESET_ALL[i*DATA_W +: DATA_W])
        ) u_word (
            .clk(clk), .rst_n(rst_n), .set_en(set_sel[i]), .clr_en(clr_sel[i]),
            .wdata(bus_wdata), .q(word_q[i*DATA_W +: DATA_W])
        );

        // R5 and R8: a read returns the word as it stood before the edge, even
        // when a write to that word lands in the same cycle.
        assert_rdback_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && rd_sel[i]) |=> (bus_rdata == $past(word_q[i*DATA_W +: DATA_W])));
    end

    scr_rdmux #(.DATA_W(DATA_W), .NWORDS(NW)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd(bus_rd), .rd_sel(rd_sel), .mapped(mapped),
        .words(word_q), .rdata(bus_rdata)
    );

    // Drive the two control vectors from the word slots.
    assign rst_lines = {word_q[int'(W_RST_HI)*DATA_W +: DATA_W], word_q[int'(W_RST_LO)*DATA_W +: DATA_W]};
    assign clk_stop  = {word_q[int'(W_CLK_HI)*DATA_W +: DATA_W], word_q[int'(W_CLK_LO)*DATA_W +: DATA_W]};
endmodule

// File: tb/scr_bank_bench.sv
module scr_bank_bench;
    localparam int PERIOD = 10;
    localparam logic [63:0] RST_KEEP = 64'h0;
    localparam logic [63:0] CLK_RUN  = 64'h0000_0004_0000_0071;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] rst_lines;
    logic [63:0] clk_stop;

    int checks = 0;
    int failures = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    scr_bank #(.RST_KEEP_MASK(RST_KEEP), .CLK_RUN_MASK(CLK_RUN)) u_scr_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rst_lines(rst_lines), .clk_stop(clk_stop)
    );

    // Reference model: plain 64-bit vectors and a read latch.
    logic [63:0] m_rst, m_clk;
    logic [31:0] m_rd;

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            12'h040, 12'h044: return m_rst[31:0];
            12'h050, 12'h054: return m_rst[63:32];
            12'h080, 12'h084: return m_clk[31:0];
            12'h090, 12'h094: return m_clk[63:32];
            default:          return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rst <= ~RST_KEEP;
            m_clk <= ~CLK_RUN;
            m_rd  <= '0;
        end else begin
            if (bus_rd) m_rd <= model_read(bus_addr);
            if (bus_wr) begin
                case (bus_addr)
                    12'h040: m_rst[31:0]  <= m_rst[31:0]  |  bus_wdata;
                    12'h044: m_rst[31:0]  <= m_rst[31:0]  & ~bus_wdata;
                    12'h050: m_rst[63:32] <= m_rst[63:32] |  bus_wdata;
                    12'h054: m_rst[63:32] <= m_rst[63:32] & ~bus_wdata;
                    12'h080: m_clk[31:0]  <= m_clk[31:0]  |  bus_wdata;
                    12'h084: m_clk[31:0]  <= m_clk[31:0]  & ~bus_wdata;
                    12'h090: m_clk[63:32] <= m_clk[63:32] |  bus_wdata;
                    12'h094: m_clk[63:32] <= m_clk[63:32] & ~bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1 rst_lines vs model", rst_lines, m_rst);
            chk("R1 clk_stop vs model", clk_stop, m_clk);
            chk("R5 rdata vs model", {32'h0, bus_rdata}, {32'h0, m_rd});
        end
    end

    task automatic bus(input bit w, input bit r, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        started = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R6 reset rst_lines", rst_lines, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R6 reset clk_stop", clk_stop, 64'hFFFF_FFFB_FFFF_FF8E);
        chk("R6 reset rdata", {32'h0, bus_rdata}, 64'h0);

        bus(0, 1, 12'h084, 32'h0);
        chk("R5 read via clear alias", {32'h0, bus_rdata}, {32'h0, 32'hFFFF_FF8E});

        bus(1, 0, 12'h044, 32'hFFFF_FFFF);
        chk("R3 clear low reset word", rst_lines, 64'hFFFF_FFFF_0000_0000);

        bus(1, 0, 12'h054, 32'h0000_0030);
        chk("R1 lines 36,37 released", rst_lines, 64'hFFFF_FFCF_0000_0000);

        bus(1, 0, 12'h040, 32'h8000_0001);
        chk("R2 set lines 0,31", rst_lines, 64'hFFFF_FFCF_8000_0001);

        bus(1, 0, 12'h040, 32'h0);
        bus(1, 0, 12'h044, 32'h0);
        chk("R4 zero writes keep rst_lines", rst_lines, 64'hFFFF_FFCF_8000_0001);

        bus(1, 0, 12'h090, 32'h0000_0004);
        chk("R2 stop clock bit 34", clk_stop, 64'hFFFF_FFFF_FFFF_FF8E);

        bus(1, 0, 12'h084, 32'h0000_0100);
        chk("R3 run clock bit 8", clk_stop, 64'hFFFF_FFFF_FFFF_FE8E);

        bus(1, 0, 12'h088, 32'hFFFF_FFFF);
        bus(1, 0, 12'h000, 32'hFFFF_FFFF);
        chk("R7 unmapped write rst_lines", rst_lines, 64'hFFFF_FFCF_8000_0001);
        chk("R7 unmapped write clk_stop", clk_stop, 64'hFFFF_FFFF_FFFF_FE8E);

        bus(0, 1, 12'h048, 32'h0);
        chk("R7 unmapped read zero", {32'h0, bus_rdata}, 64'h0);

        bus(1, 1, 12'h044, 32'h8000_0000);
        chk("R8 read returns pre-write value", {32'h0, bus_rdata}, {32'h0, 32'h8000_0001});
        chk("R8 write still applied", rst_lines, 64'hFFFF_FFCF_0000_0001);

        bus(0, 0, 12'h040, 32'h0);
        chk("R5 rdata held without strobe", {32'h0, bus_rdata}, {32'h0, 32'h8000_0001});

        seed = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            seed = seed * 32'd1664525 + 32'd1013904223;
            case (seed[27:24])
                4'd0: a = 12'h040;  4'd1: a = 12'h044;  4'd2: a = 12'h050;
                4'd3: a = 12'h054;  4'd4: a = 12'h080;  4'd5: a = 12'h084;
                4'd6: a = 12'h090;  4'd7: a = 12'h094;  4'd8: a = 12'h048;
                4'd9: a = 12'h08C;  4'd10: a = 12'h0A0; default: a = 12'h040 + 12'(seed[31:30]) * 12'h10;
            endcase
            @(negedge clk);
            bus_wr = seed[20]; bus_rd = seed[21]; bus_addr = a;
            bus_wdata = seed ^ {seed[15:0], seed[31:16]};
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule